// File: doc/BRIEF.md
# Floppy Track Format Sequencer

This block runs the whole-track format command of a floppy disk controller. A command strobe starts it. It waits out a fixed head-settle time counted in input clocks, then raises its first byte request to the host. The host answers each request by presenting a byte with a one-cycle acknowledge. The block waits a guard interval of a few byte times, and the first index pulse edge after that interval marks the start of the track. From that point it sends one byte after another to a serial bit output, most significant bit first.

All bit pacing comes from a free-running divider. The divider divides the input clock by 8 in double-density mode and by 16 in single-density mode. It is never cleared by a new command, so the start of a command has up to one bit period of phase uncertainty. A host byte of 0xF7 is a request to write the running CRC in place of that byte. If 0xF7 bytes arrive back to back, CRC output and a literal 0xF7 take turns.

A byte slot that finds no host byte raises a sticky lost-data flag and sends 0x00 instead. The track ends at the next index edge. A force-interrupt input also ends the command, but only after a fixed number of further bit times.

Top module: `wtk_format_engine`

## Requirements
- R1: A `cmd_go` pulse while idle raises `busy` on the next clock. A `cmd_go` pulse while `busy` is high has no effect on the byte stream.
- R2: `drq` stays low for exactly HEAD_LOAD_CLKS clocks after `busy` rises (default 20000), then goes high.
- R3: Index rising edges during the first GUARD_BITS bit times after the first `drq` are ignored (default 24). The first index rising edge after that interval starts writing at the next bit tick. No `ser_valid` occurs before writing starts.
- R4: While writing, `ser_valid` pulses for one clock every 8 clocks when `mfm`=1 and every 16 clocks when `mfm`=0. `ser_bit` carries the bytes most significant bit first.
- R5: The bit divider counts from reset only. Bit strobes of different commands in the same mode keep the same phase modulo the divide ratio.
- R6: `drq` is high whenever the one-byte holding register is empty during a command. A `host_valid` pulse while `drq` is high loads `host_byte`, and `drq` is low on the next clock. A `host_valid` pulse while `drq` is low is ignored.
- R7: When a host byte of 0xF7 reaches the serializer, two slots carry the CRC, high byte first. The CRC is CRC-16 with polynomial 0x1021, preset to 0xFFFF, and covers the bytes written since the last CRC emission. The second slot takes no host byte. A 0xF7 that immediately follows such a CRC is written literally, and the next 0xF7 after that emits CRC again.
- R8: A slot with no host byte available writes 0x00 and sets `lost_data`. The flag stays set until the next command starts, and it is low after that start.
- R9: While writing, an index rising edge ends the command. `busy` and `drq` are low on the next clock, and no further `ser_valid` occurs.
- R10: `force_irq` during a command ends it after FI_BITS bit ticks (default 12). `busy` falls between (FI_BITS-1) and FI_BITS bit periods after the request, never at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Format command strobe |
| mfm | input | 1 | 1 = double density (divide by 8), 0 = single density (divide by 16) |
| index_in | input | 1 | Index pulse from the drive |
| host_byte | input | 8 | Byte supplied by the host |
| host_valid | input | 1 | One-cycle acknowledge that qualifies `host_byte` |
| force_irq | input | 1 | Request to abort the running command |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | Strobe marking a valid `ser_bit` |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Byte request to the host |
| lost_data | output | 1 | Sticky flag: a byte slot found no host byte |

## Verification
The bench checks that the first request comes after exactly the head-settle count. Releasing it early would mirror a controller that requests data before the head is loaded. An index pulse is sent inside the guard window, where a design that acted on it would start the track too soon. A run of four consecutive 0xF7 bytes checks the CRC/literal alternation and the CRC restart after each emission. A design that always emitted CRC, or carried the CRC across emissions, would give the wrong bytes. The bench also checks that bit strobes of two commands keep one divider phase, which catches a divider cleared by the command. It measures force-interrupt latency against a window, which catches an abort that happens at once or one that never happens.

// File: rtl/wtk_pkg.sv
package wtk_pkg;

    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [7:0]  CRC_MARK   = 8'hF7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HLOAD,
        ST_GUARD,
        ST_WRITE
    } wtk_state_e;

    typedef enum logic [1:0] {
        SLOT_DATA,
        SLOT_LOST,
        SLOT_CRC_HI,
        SLOT_CRC_LO
    } wtk_slot_e;

endpackage

// File: rtl/wtk_bitdiv.sv
module wtk_bitdiv #(
    parameter int DIV_MFM = 8,
    parameter int DIV_FM  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mfm,
    output logic bit_tick
);
    localparam int DMAX = (DIV_FM > DIV_MFM) ? DIV_FM : DIV_MFM;
    localparam int CW   = $clog2(DMAX);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim      = mfm ? CW'(DIV_MFM - 1) : CW'(DIV_FM - 1);
        bit_tick = (cnt_q >= lim);
        cnt_d    = bit_tick ? '0 : cnt_q + 1'b1;
    end

    // Only reset clears the divider; commands never touch it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wtk_crc_step.sv
module wtk_crc_step #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    always_comb begin
        logic [15:0] acc;
        acc = crc_i ^ {byte_i, 8'h00};
        for (int i = 0; i < 8; i++) begin
            acc = acc[15] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_o = acc;
    end
endmodule

// File: rtl/wtk_format_engine.sv
module wtk_format_engine
    import wtk_pkg::*;
#(
    parameter int HEAD_LOAD_CLKS = 20000,
    parameter int GUARD_BITS     = 24,
    parameter int FI_BITS        = 12,
    parameter int DIV_MFM        = 8,
    parameter int DIV_FM         = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic       mfm,
    input  logic       index_in,
    input  logic [7:0] host_byte,
    input  logic       host_valid,
    input  logic       force_irq,
    output logic       ser_bit,
    output logic       ser_valid,
    output logic       busy,
    output logic       drq,
    output logic       lost_data
);
    localparam int HLW = $clog2(HEAD_LOAD_CLKS + 1);
    localparam int GW  = $clog2(GUARD_BITS + 1);
    localparam int FW  = $clog2(FI_BITS + 1);

    typedef struct packed {
        wtk_state_e  st;
        logic [HLW-1:0] hl_cnt;
        logic [GW-1:0]  gcnt;
        logic        guard_done;
        logic        fi_act;
        logic [FW-1:0] fi_cnt;
        logic        drq;
        logic [7:0]  hold;
        logic        hold_full;
        logic [7:0]  sh;
        logic [2:0]  bitcnt;
        logic [15:0] crc;
        logic        crc_lo_pend;
        logic [7:0]  crc_lo;
        logic        f7_alt;
        logic        lost;
        logic        ser_bit;
        logic        ser_valid;
        logic        idx_q;
    } wtk_regs_t;

    wtk_regs_t r_d, r_q;

    logic        bit_tick;
    logic        idx_rise;
    wtk_slot_e   slot_kind;
    logic [7:0]  slot_byte;
    logic [15:0] crc_next;

    wtk_bitdiv #(.DIV_MFM(DIV_MFM), .DIV_FM(DIV_FM)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .mfm      (mfm),
        .bit_tick (bit_tick)
    );

    // Choose what the next byte slot carries.
    always_comb begin
        if (r_q.crc_lo_pend) begin
            slot_kind = SLOT_CRC_LO;
            slot_byte = r_q.crc_lo;
        end else if (!r_q.hold_full) begin
            slot_kind = SLOT_LOST;
            slot_byte = 8'h00;
        end else if (r_q.hold == CRC_MARK && !r_q.f7_alt) begin
            slot_kind = SLOT_CRC_HI;
            slot_byte = r_q.crc[15:8];
        end else begin
            slot_kind = SLOT_DATA;
            slot_byte = r_q.hold;
        end
    end

    wtk_crc_step #(.POLY(CRC_POLY)) u_crc (
        .crc_i  (r_q.crc),
        .byte_i (slot_byte),
        .crc_o  (crc_next)
    );

    always_comb begin
        r_d           = r_q;
        r_d.ser_valid = 1'b0;
        r_d.idx_q     = index_in;
        idx_rise      = index_in & ~r_q.idx_q;

        if (r_q.drq && host_valid) begin
            r_d.hold      = host_byte;
            r_d.hold_full = 1'b1;
            r_d.drq       = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_go) begin
                    r_d.st          = ST_HLOAD;
                    r_d.hl_cnt      = HLW'(HEAD_LOAD_CLKS - 1);
                    r_d.gcnt        = '0;
                    r_d.guard_done  = 1'b0;
                    r_d.fi_act      = 1'b0;
                    r_d.fi_cnt      = '0;
                    r_d.drq         = 1'b0;
                    r_d.hold_full   = 1'b0;
                    r_d.crc         = CRC_PRESET;
                    r_d.crc_lo_pend = 1'b0;
                    r_d.f7_alt      = 1'b0;
                    r_d.lost        = 1'b0;
                end
            end
            ST_HLOAD: begin
                if (r_q.hl_cnt == '0) begin
                    r_d.st  = ST_GUARD;
                    r_d.drq = 1'b1;
                end else begin
                    r_d.hl_cnt = r_q.hl_cnt - 1'b1;
                end
            end
            ST_GUARD: begin
                if (bit_tick && !r_q.guard_done) begin
                    r_d.gcnt = r_q.gcnt + 1'b1;
                    if (r_q.gcnt == GW'(GUARD_BITS - 1)) r_d.guard_done = 1'b1;
                end
                if (r_q.guard_done && idx_rise) begin
                    r_d.st     = ST_WRITE;
                    r_d.bitcnt = 3'd0;
                end
            end
            ST_WRITE: begin
                if (idx_rise) begin
                    r_d.st  = ST_IDLE;
                    r_d.drq = 1'b0;
                end else if (bit_tick) begin
                    r_d.ser_valid = 1'b1;
                    if (r_q.bitcnt == 3'd0) begin
                        r_d.ser_bit = slot_byte[7];
                        r_d.sh      = {slot_byte[6:0], 1'b0};
                        r_d.bitcnt  = 3'd7;
                        unique case (slot_kind)
                            SLOT_CRC_LO: begin
                                r_d.crc_lo_pend = 1'b0;
                                r_d.crc         = CRC_PRESET;
                            end
                            SLOT_LOST: begin
                                r_d.lost   = 1'b1;
                                r_d.crc    = crc_next;
                                r_d.f7_alt = 1'b0;
                            end
                            SLOT_CRC_HI: begin
                                r_d.crc_lo      = r_q.crc[7:0];
                                r_d.crc_lo_pend = 1'b1;
                                r_d.f7_alt      = 1'b1;
                                r_d.hold_full   = 1'b0;
                                r_d.drq         = 1'b1;
                            end
                            default: begin
                                r_d.crc       = crc_next;
                                r_d.f7_alt    = 1'b0;
                                r_d.hold_full = 1'b0;
                                r_d.drq       = 1'b1;
                            end
                        endcase
                    end else begin
                        r_d.ser_bit = r_q.sh[7];
                        r_d.sh      = {r_q.sh[6:0], 1'b0};
                        r_d.bitcnt  = r_q.bitcnt - 3'd1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // Abort path: counts bit ticks before taking effect.
        if (r_q.st != ST_IDLE) begin
            if (r_q.fi_act) begin
                if (bit_tick) begin
                    if (r_q.fi_cnt == FW'(FI_BITS - 1)) begin
                        r_d.st        = ST_IDLE;
                        r_d.drq       = 1'b0;
                        r_d.fi_act    = 1'b0;
                        r_d.ser_valid = 1'b0;
                    end else begin
                        r_d.fi_cnt = r_q.fi_cnt + 1'b1;
                    end
                end
            end else if (force_irq) begin
                r_d.fi_act = 1'b1;
                r_d.fi_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ser_bit   = r_q.ser_bit;
    assign ser_valid = r_q.ser_valid;
    assign busy      = (r_q.st != ST_IDLE);
    assign drq       = r_q.drq;
    assign lost_data = r_q.lost;

endmodule

// File: rtl/wtk_format_checker.sv
module wtk_format_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic drq,
    input logic ser_valid,
    input logic lost_data
);
    // R4: strobes are at least two clocks apart
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |=> !ser_valid);

    // R6: a request exists only inside a command
    a_r6_drq_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> busy);

    // R9: no serial output outside a command
    a_r9_ser_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> busy);

    // R8: lost flag holds for the rest of a command
    a_r8_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(lost_data)) |-> lost_data);

    // R2: no request in the cycle a command begins
    a_r2_no_drq_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !drq);
endmodule

bind wtk_format_engine wtk_format_checker u_wtk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .drq       (drq),
    .ser_valid (ser_valid),
    .lost_data (lost_data)
);

// File: tb/wtk_format_engine_tb.sv
module wtk_format_engine_tb_top;
    localparam int HL  = 2000;
    localparam int GB  = 24;
    localparam int FIB = 12;

    localparam logic [7:0] STIM [10] = '{8'h4E, 8'h4E, 8'hA1, 8'hFE, 8'h01,
                                         8'hF7, 8'hF7, 8'hF7, 8'hF7, 8'h55};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0;
    logic       mfm = 1'b1;
    logic       index_in = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       host_valid = 1'b0;
    logic       force_irq = 1'b0;
    logic       ser_bit, ser_valid, busy, drq, lost_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] feed_q [16];
    logic [7:0] got [16];
    logic [7:0] expv [16];
    int exp_n;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wtk_format_engine #(.HEAD_LOAD_CLKS(HL), .GUARD_BITS(GB), .FI_BITS(FIB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .mfm(mfm), .index_in(index_in),
        .host_byte(host_byte), .host_valid(host_valid), .force_irq(force_irq),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .busy(busy), .drq(drq),
        .lost_data(lost_data)
    );

    task automatic chk(input string req, input int act, input int expd);
        checks++;
        if (act !== expd) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // Build the expected stream from n host bytes plus one lost slot.
    task automatic build_expect(input int n);
        logic [15:0] c;
        logic alt;
        c = 16'hFFFF; alt = 1'b0; exp_n = 0;
        for (int k = 0; k < n; k++) begin
            if (feed_q[k] == 8'hF7 && !alt) begin
                expv[exp_n] = c[15:8]; expv[exp_n+1] = c[7:0];
                exp_n += 2; c = 16'hFFFF; alt = 1'b1;
            end else begin
                expv[exp_n] = feed_q[k]; exp_n++;
                c = crc_upd(c, feed_q[k]); alt = 1'b0;
            end
        end
        expv[exp_n] = 8'h00; exp_n++;
    endtask

    task automatic feed(input int n);
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (!drq);
            host_byte = feed_q[k]; host_valid = 1'b1;
            @(negedge clk);
            host_valid = 1'b0;
            if (k == 2) begin
                host_byte = 8'hEE; host_valid = 1'b1;   // R6: drq is low here
                @(negedge clk);
                host_valid = 1'b0;
            end
        end
    endtask

    task automatic collect(input int nbytes, input int per, output int first_cyc);
        int waitc, gap, badgap;
        waitc = 0; badgap = 0;
        do begin @(negedge clk); waitc++; end while (!ser_valid && waitc < 5000);
        first_cyc = cyc;
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                if (!(b == 0 && i == 7)) begin
                    gap = 0;
                    do begin @(negedge clk); gap++; end while (!ser_valid && gap < 100);
                    if (gap != per) badgap++;
                end
                got[b][i] = ser_bit;
            end
        end
        chk("R4 strobe spacing mismatches", badgap, 0);
    endtask

    task automatic start_cmd();
        @(negedge clk); cmd_go = 1'b1;
        @(negedge clk); cmd_go = 1'b0;
    endtask

    task automatic pulse_index();
        @(negedge clk); index_in = 1'b1;
        repeat (4) @(negedge clk);
        index_in = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t1, t2, quiet, lat, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset busy", busy, 0);
        chk("reset drq", drq, 0);
        chk("reset ser_valid", ser_valid, 0);
        chk("reset lost_data", lost_data, 0);

        // ---------- double density, table-driven stream ----------
        for (int k = 0; k < 10; k++) feed_q[k] = STIM[k];
        build_expect(10);
        @(negedge clk); cmd_go = 1'b1;
        for (int i = 1; i <= HL + 1; i++) begin
            @(negedge clk);
            if (i == 1) begin cmd_go = 1'b0; chk("R1 busy after cmd_go", busy, 1); end
            if (i == HL) chk("R2 drq low during head load", drq, 0);
            if (i == HL + 1) chk("R2 drq high after head load", drq, 1);
        end
        fork feed(10); join_none
        quiet = 0;
        repeat (40) begin @(negedge clk); if (ser_valid) quiet++; end
        fork pulse_index(); join_none                  // inside guard window
        repeat (300) begin @(negedge clk); if (ser_valid) quiet++; end
        chk("R3 no output before accepted index", quiet, 0);
        chk("R8 lost low before writing", lost_data, 0);
        fork pulse_index(); join_none
        collect(exp_n, 8, t1);
        bad = 0;
        for (int b = 0; b < exp_n - 1; b++) begin
            if (got[b] !== expv[b]) begin
                bad++;
                $display("FAIL R7 byte %0d actual=%0h expected=%0h", b, got[b], expv[b]);
            end
        end
        chk("R7 stream mismatches", bad, 0);
        chk("R6 byte after ignored strobe", got[3], 8'hFE);
        chk("R7 literal F7 after CRC", got[7], 8'hF7);
        chk("R8 lost slot writes zero", got[exp_n-1], 8'h00);
        chk("R8 lost flag set", lost_data, 1);
        @(negedge clk); index_in = 1'b1;
        @(negedge clk);
        chk("R9 busy low after end index", busy, 0);
        chk("R9 drq low after end index", drq, 0);
        index_in = 1'b0;
        quiet = 0;
        repeat (40) begin @(negedge clk); if (ser_valid) quiet++; end
        chk("R9 no output after end", quiet, 0);

        // ---------- force interrupt, double density, shifted start ----------
        repeat (3) @(negedge clk);
        start_cmd();
        do @(negedge clk); while (!drq);
        repeat (250) @(negedge clk);
        pulse_index();
        do @(negedge clk); while (!ser_valid);
        t2 = cyc;
        chk("R5 divider phase kept across commands", (t2 - t1) % 8, 0);
        repeat (20) @(negedge clk);
        force_irq = 1'b1;
        @(negedge clk); force_irq = 1'b0;
        lat = 1;
        while (busy && lat < 400) begin @(negedge clk); lat++; end
        chk("R10 not immediate", (lat >= (FIB - 1) * 8) ? 1 : 0, 1);
        chk("R10 ends within window", (lat <= FIB * 8 + 3) ? 1 : 0, 1);
        chk("R10 drq low after abort", drq, 0);

        // ---------- single density, CRC first, retrigger ignored ----------
        repeat (5) @(negedge clk);
        mfm = 1'b0;
        feed_q[0] = 8'hF7; feed_q[1] = 8'hF7; feed_q[2] = 8'h12;
        build_expect(3);
        start_cmd();
        do @(negedge clk); while (!drq);
        chk("R8 lost cleared by new command", lost_data, 0);
        fork feed(3); join_none
        repeat (450) @(negedge clk);
        fork
            pulse_index();
            begin
                repeat (200) @(negedge clk);
                cmd_go = 1'b1;                         // R1: ignored while busy
                @(negedge clk); cmd_go = 1'b0;
            end
        join_none
        collect(exp_n, 16, t1);
        bad = 0;
        for (int b = 0; b < exp_n; b++) if (got[b] !== expv[b]) bad++;
        chk("R1 R7 single density stream", bad, 0);
        chk("R7 CRC of empty run high", got[0], 8'hFF);
        @(negedge clk); index_in = 1'b1;
        @(negedge clk);
        chk("R9 single density end", busy, 0);
        index_in = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule